// File: doc/BRIEF.md
# 64b/66b Block Decoder with Packet-Order Checking

This block sits on the receive side of a 64b/66b serial link. It takes blocks that are already aligned: a 2-bit header and a 64-bit scrambled body. It removes the scrambling with a self-synchronous descrambler. It then reads the header and, for mixed blocks, the block-type byte. It spreads the result over eight byte lanes. Each lane carries a flag that marks it as a control character. The 7-bit control codes in mixed blocks are turned back into 8-bit control characters. Start and terminate markers are rebuilt from the block type.

A small state machine follows each packet from one block to the next. A single bit error in the header can turn a start or terminate block into a data block, or the reverse, and the result is a block order that is not allowed. When the state machine sees such an order, it replaces the whole block with error characters, so the receiver drops the packet. Bad headers and unknown block types are also replaced with error characters. An unknown control code only affects its own lane. The block has one register stage from input to output.

Top module: `dec66_rx`

## Requirements
- R1: Descrambling follows x^58 + x^19 + 1, taking body bits LSB first and running continuously across blocks: plain bit i = c[i] ^ c[i-39] ^ c[i-58], where c is the stream of received scrambled bits.
- R2: `out_valid` goes high one cycle after an accepted input block. It stays low for the first block after reset, because the descrambler history is not yet filled, and it stays low in the cycle after `in_valid` is low.
- R3: Header 2'b01 is a data block. Lane k takes plain bits [8k+7:8k], and all control flags are 0.
- R4: Header 2'b00 or 2'b11 is a code error. All eight lanes become the error character 0xFE, and all eight control flags are 1.
- R5: Header 2'b10 with type 0x17 (the type is plain bits [7:0]) is an all-control block. Lane k's 7-bit code sits at plain bits [8+7k+6:8+7k].
- R6: Type 0x71 is a start in lane 0: lane 0 = 0xFB (control), and lanes 1..7 are data taken from bits [8k+7:8k]. Type 0x3C is a start in lane 4: lanes 0..3 are codes at [8+7k+6:8+7k], lane 4 = 0xFB, and lanes 5..7 are data taken from bits [8k+7:8k].
- R7: Types 0x8E, 0x99, 0xA5, 0xB2, 0xC3, 0xD4, 0xE8 and 0xFF are terminates at positions p = 0..7. Lanes below p are data taken from bits [8+8k+7:8+8k], lane p = 0xFD (control), and lanes above p are codes at [8+7k+6:8+7k].
- R8: Codes map to control characters as follows: 0x16→0xBC, 0x19→0x3C, 0x25→0x1C, 0x2A→0xF7, 0x43→0xFE, 0x4C→0xFC. Any other code, including 0x70 and 0x7F, gives 0xFE in that lane only.
- R9: Header 2'b10 with a type that is not one of the eleven above gives 0xFE with the control flag set in all eight lanes.
- R10: Packet order is checked. Outside a packet, a data or terminate block is a violation. Inside a packet, a start or all-control block is a violation. A violation makes all lanes 0xFE with control flags set. The state after a block is: start leads to inside, terminate or all-control leads to outside, and any other block keeps the state.
- R11: Reset puts the order checker outside a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Block present on `in_hdr`/`in_body` |
| in_hdr | input | 2 | Block header (sync preamble) |
| in_body | input | 64 | Scrambled block body, bit 0 first on the line |
| out_valid | output | 1 | Decoded lanes valid |
| out_data | output | 64 | Lane k at bits [8k+7:8k] |
| out_ctrl | output | 8 | Bit k set when lane k is a control character |

## Verification
Every decoded result, including a forced error block, appears exactly one clock edge after the block is presented. The bench therefore drives a block on a falling edge and checks the outputs on the next falling edge, before it drives the block after that. Changes to the order state are seen only through the following block, so the table is walked as one continuous stream. Each row's expected lanes depend on the state left by the earlier rows. The priming block after reset is checked for `out_valid` low in its own output cycle.

// File: rtl/dec66_pkg.sv
package dec66_pkg;
  typedef enum logic [2:0] {BK_CTRL, BK_START, BK_TERM, BK_DATA, BK_BAD} blk_kind_e;

  localparam logic [7:0] CH_START = 8'hFB;
  localparam logic [7:0] CH_TERM  = 8'hFD;
  localparam logic [7:0] CH_ERR   = 8'hFE;

  localparam logic [7:0] TY_CTRL   = 8'h17;
  localparam logic [7:0] TY_START0 = 8'h71;
  localparam logic [7:0] TY_START4 = 8'h3C;
  // terminate type for end position p sits at [8p+7:8p]
  localparam logic [63:0] TY_TERMS = {8'hFF, 8'hE8, 8'hD4, 8'hC3,
                                      8'hB2, 8'hA5, 8'h99, 8'h8E};

  function automatic logic [7:0] code_to_char(input logic [6:0] code);
    case (code)
      7'h16:   return 8'hBC;
      7'h19:   return 8'h3C;
      7'h25:   return 8'h1C;
      7'h2A:   return 8'hF7;
      7'h43:   return 8'hFE;
      7'h4C:   return 8'hFC;
      default: return CH_ERR;
    endcase
  endfunction
endpackage

// File: rtl/dec66_descrambler.sv
module dec66_descrambler #(
  parameter int W        = 64,
  parameter int POLY_LEN = 58,
  parameter int POLY_TAP = 39
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         primed
);
  localparam int PRIME_N = (POLY_LEN + W - 1) / W;
  localparam int CW      = $clog2(PRIME_N + 1);
  localparam int OFS     = POLY_LEN - POLY_TAP;

  logic [POLY_LEN-1:0]   hist_q;
  logic [W+POLY_LEN-1:0] ext;
  logic [CW-1:0]         cnt_q;

  assign ext    = {din, hist_q};
  assign primed = (cnt_q == CW'(PRIME_N));

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dout[i] = ext[i+POLY_LEN] ^ ext[i+OFS] ^ ext[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      hist_q <= din[W-1:W-POLY_LEN];
      if (!primed) cnt_q <= cnt_q + CW'(1);
    end
  end

  AST_PRIME_MONO: assert property (@(posedge clk) disable iff (rst)
    primed |=> primed);  // R2
endmodule

// File: rtl/dec66_unpack.sv
module dec66_unpack
  import dec66_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic [1:0]         hdr,
  input  logic [8*LANES-1:0] body,
  output logic [8*LANES-1:0] lane_data,
  output logic [LANES-1:0]   lane_ctrl,
  output blk_kind_e          kind
);
  logic [7:0] ty;
  logic [7:0] cmap [LANES];
  logic [7:0] ld   [LANES];
  logic [LANES-1:0] lc;

  assign ty = body[7:0];

  for (genvar k = 0; k < LANES; k++) begin : g_code
    assign cmap[k] = code_to_char(body[8+7*k +: 7]);
    assign lane_data[8*k +: 8] = ld[k];
  end
  assign lane_ctrl = lc;

  always_comb begin
    kind = BK_BAD;
    lc   = '1;
    for (int k = 0; k < LANES; k++) ld[k] = CH_ERR;
    if (hdr == 2'b01) begin
      kind = BK_DATA;
      lc   = '0;
      for (int k = 0; k < LANES; k++) ld[k] = body[8*k +: 8];
    end else if (hdr == 2'b10) begin
      if (ty == TY_CTRL) begin
        kind = BK_CTRL;
        for (int k = 0; k < LANES; k++) ld[k] = cmap[k];
      end else if (ty == TY_START0) begin
        kind  = BK_START;
        ld[0] = CH_START;
        for (int k = 1; k < LANES; k++) begin
          ld[k] = body[8*k +: 8];
          lc[k] = 1'b0;
        end
      end else if (ty == TY_START4) begin
        kind = BK_START;
        for (int k = 0; k < LANES; k++) begin
          if (k < 4)       ld[k] = cmap[k];
          else if (k == 4) ld[k] = CH_START;
          else begin
            ld[k] = body[8*k +: 8];
            lc[k] = 1'b0;
          end
        end
      end else begin
        for (int p = 0; p < LANES; p++) begin
          if (ty == TY_TERMS[8*p +: 8]) begin
            kind = BK_TERM;
            for (int k = 0; k < LANES; k++) begin
              if (k < p) begin
                ld[k] = body[8+8*k +: 8];
                lc[k] = 1'b0;
              end else if (k == p) begin
                ld[k] = CH_TERM;
              end else begin
                ld[k] = cmap[k];
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/dec66_seq.sv
module dec66_seq
  import dec66_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      blk_valid,
  input  blk_kind_e kind,
  output logic      force_err
);
  logic in_pkt_q;
  logic in_pkt_d;

  always_comb begin
    force_err = 1'b0;
    in_pkt_d  = in_pkt_q;
    if (blk_valid) begin
      if (in_pkt_q) force_err = (kind == BK_START) || (kind == BK_CTRL);
      else          force_err = (kind == BK_DATA)  || (kind == BK_TERM);
      case (kind)
        BK_START:         in_pkt_d = 1'b1;
        BK_TERM, BK_CTRL: in_pkt_d = 1'b0;
        default:          in_pkt_d = in_pkt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) in_pkt_q <= 1'b0;
    else     in_pkt_q <= in_pkt_d;
  end

  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !blk_valid |=> $stable(in_pkt_q));  // R10
  AST_START_ENTERS: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && kind == BK_START) |=> in_pkt_q);  // R10
  AST_TERM_LEAVES: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && kind == BK_TERM) |=> !in_pkt_q);  // R10
  AST_RESET_OUTSIDE: assert property (@(posedge clk)
    $past(rst) |-> !in_pkt_q);  // R11
endmodule

// File: rtl/dec66_rx.sv
module dec66_rx
  import dec66_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int POLY_LEN = 58,
  parameter int POLY_TAP = 39
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [1:0]         in_hdr,
  input  logic [8*LANES-1:0] in_body,
  output logic               out_valid,
  output logic [8*LANES-1:0] out_data,
  output logic [LANES-1:0]   out_ctrl
);
  localparam int BW = 8 * LANES;

  logic [BW-1:0]    plain;
  logic             primed;
  logic [BW-1:0]    lane_data;
  logic [LANES-1:0] lane_ctrl;
  blk_kind_e        kind;
  logic             blk_ok;
  logic             seq_force;

  dec66_descrambler #(.W(BW), .POLY_LEN(POLY_LEN), .POLY_TAP(POLY_TAP)) u_descr (
    .clk(clk), .rst(rst), .en(in_valid), .din(in_body),
    .dout(plain), .primed(primed)
  );

  dec66_unpack #(.LANES(LANES)) u_unpack (
    .hdr(in_hdr), .body(plain),
    .lane_data(lane_data), .lane_ctrl(lane_ctrl), .kind(kind)
  );

  assign blk_ok = in_valid && primed;

  dec66_seq u_seq (
    .clk(clk), .rst(rst), .blk_valid(blk_ok), .kind(kind), .force_err(seq_force)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ctrl  <= '0;
    end else begin
      out_valid <= blk_ok;
      if (seq_force) begin
        out_data <= {LANES{CH_ERR}};
        out_ctrl <= '1;
      end else begin
        out_data <= lane_data;
        out_ctrl <= lane_ctrl;
      end
    end
  end

  AST_PRIME_GATE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !primed) |=> !out_valid);  // R2
  AST_VALID_SRC: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));  // R2
  AST_FORCE_ALL_ERR: assert property (@(posedge clk) disable iff (rst)
    (blk_ok && seq_force) |=> (out_ctrl == '1 && out_data == {LANES{CH_ERR}}));  // R10
  AST_BAD_HDR_ERR: assert property (@(posedge clk) disable iff (rst)
    (blk_ok && (in_hdr == 2'b00 || in_hdr == 2'b11)) |=> (out_ctrl == '1));  // R4
endmodule

// File: tb/dec66_rx_tb.sv
module dec66_rx_tb_top;
  localparam int NV = 29;
  localparam int MAX_CYC = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_hdr = 2'b00;
  logic [63:0] in_body = '0;
  logic        out_valid;
  logic [63:0] out_data;
  logic [7:0]  out_ctrl;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [57:0] sh = '0;

  always #5 clk = ~clk;

  dec66_rx dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_hdr(in_hdr),
    .in_body(in_body), .out_valid(out_valid), .out_data(out_data),
    .out_ctrl(out_ctrl)
  );

  // row: {hdr[2], type[8], code[7], seed[8], all_err[1], req[4]}
  localparam logic [29:0] VEC [NV] = '{
    {2'b10, 8'h17, 7'h16, 8'h00, 1'b0, 4'd5},   // R5 idle control
    {2'b10, 8'h17, 7'h19, 8'h00, 1'b0, 4'd8},   // R8 busy idle
    {2'b10, 8'h71, 7'h00, 8'h10, 1'b0, 4'd6},   // R6 start lane 0
    {2'b01, 8'h00, 7'h00, 8'h20, 1'b0, 4'd3},   // R3 data in packet
    {2'b10, 8'hB2, 7'h16, 8'h30, 1'b0, 4'd7},   // R7 end at 3
    {2'b10, 8'h3C, 7'h25, 8'h40, 1'b0, 4'd6},   // R6 start lane 4
    {2'b10, 8'hFF, 7'h00, 8'h50, 1'b0, 4'd7},   // R7 end at 7
    {2'b10, 8'h71, 7'h00, 8'h60, 1'b0, 4'd6},
    {2'b10, 8'hD4, 7'h70, 8'h70, 1'b0, 4'd8},   // R8 reserved code per lane
    {2'b01, 8'h00, 7'h00, 8'h80, 1'b1, 4'd10},  // R10 data outside
    {2'b10, 8'h17, 7'h2A, 8'h00, 1'b0, 4'd8},
    {2'b10, 8'h8E, 7'h16, 8'h00, 1'b1, 4'd10},  // R10 end outside
    {2'b10, 8'h71, 7'h00, 8'h90, 1'b0, 4'd6},
    {2'b10, 8'h3C, 7'h16, 8'hA0, 1'b1, 4'd10},  // R10 start inside
    {2'b10, 8'h17, 7'h16, 8'h00, 1'b1, 4'd10},  // R10 control inside
    {2'b00, 8'h00, 7'h00, 8'hB0, 1'b1, 4'd4},   // R4 header 00
    {2'b10, 8'h55, 7'h16, 8'h00, 1'b1, 4'd9},   // R9 unknown type
    {2'b10, 8'h71, 7'h00, 8'hC0, 1'b0, 4'd6},
    {2'b11, 8'h00, 7'h00, 8'hD0, 1'b1, 4'd4},   // R4 header 11
    {2'b10, 8'h8E, 7'h4C, 8'h00, 1'b0, 4'd7},   // R7 end at 0
    {2'b10, 8'h71, 7'h00, 8'hE0, 1'b0, 4'd6},
    {2'b10, 8'h99, 7'h43, 8'h00, 1'b0, 4'd7},   // R7 end at 1
    {2'b10, 8'h71, 7'h00, 8'h01, 1'b0, 4'd6},
    {2'b10, 8'hA5, 7'h16, 8'h11, 1'b0, 4'd7},   // R7 end at 2
    {2'b10, 8'h71, 7'h00, 8'h21, 1'b0, 4'd6},
    {2'b10, 8'hC3, 7'h19, 8'h31, 1'b0, 4'd7},   // R7 end at 4
    {2'b10, 8'h71, 7'h00, 8'h41, 1'b0, 4'd6},
    {2'b10, 8'hE8, 7'h25, 8'h51, 1'b0, 4'd7},   // R7 end at 6
    {2'b10, 8'h17, 7'h7F, 8'h00, 1'b0, 4'd8}    // R8 reserved code 0x7F
  };

  function automatic logic [7:0] ref_char(input logic [6:0] c);
    if (c == 7'h4C) return 8'hFC;
    if (c == 7'h2A) return 8'hF7;
    if (c == 7'h25) return 8'h1C;
    if (c == 7'h19) return 8'h3C;
    if (c == 7'h16) return 8'hBC;
    return 8'hFE;
  endfunction

  function automatic int end_pos(input logic [7:0] t);
    case (t)
      8'h8E: return 0;  8'h99: return 1;  8'hA5: return 2;  8'hB2: return 3;
      8'hC3: return 4;  8'hD4: return 5;  8'hE8: return 6;  8'hFF: return 7;
      default: return -1;
    endcase
  endfunction

  // plain body per R3, R5, R6, R7
  function automatic logic [63:0] mk_body(input logic [1:0] h, input logic [7:0] t,
                                          input logic [6:0] c, input logic [7:0] s);
    logic [63:0] b;
    int p;
    for (int k = 0; k < 8; k++) b[8*k +: 8] = s + 8'(k);
    if (h == 2'b10) begin
      p = end_pos(t);
      b[7:0] = t;
      if (t == 8'h17) begin
        for (int k = 0; k < 8; k++) b[8+7*k +: 7] = c;
      end else if (t == 8'h3C) begin
        for (int k = 0; k < 4; k++) b[8+7*k +: 7] = c;
      end else if (p >= 0) begin
        for (int k = 0; k < 8; k++) begin
          if (k < p)      b[8+8*k +: 8] = s + 8'(k);
          else if (k > p) b[8+7*k +: 7] = c;
        end
      end
    end
    return b;
  endfunction

  function automatic logic [71:0] mk_exp(input logic [1:0] h, input logic [7:0] t,
                                         input logic [6:0] c, input logic [7:0] s,
                                         input logic err);
    logic [63:0] d;
    logic [7:0]  f;
    int p;
    d = {8{8'hFE}};
    f = 8'hFF;
    if (!err) begin
      p = end_pos(t);
      for (int k = 0; k < 8; k++) begin
        if (h == 2'b01) begin
          d[8*k +: 8] = s + 8'(k); f[k] = 1'b0;
        end else if (t == 8'h17) begin
          d[8*k +: 8] = ref_char(c);
        end else if (t == 8'h71) begin
          if (k == 0) d[7:0] = 8'hFB;
          else begin d[8*k +: 8] = s + 8'(k); f[k] = 1'b0; end
        end else if (t == 8'h3C) begin
          if (k < 4)       d[8*k +: 8] = ref_char(c);
          else if (k == 4) d[8*k +: 8] = 8'hFB;
          else begin d[8*k +: 8] = s + 8'(k); f[k] = 1'b0; end
        end else begin
          if (k < p)       begin d[8*k +: 8] = s + 8'(k); f[k] = 1'b0; end
          else if (k == p) d[8*k +: 8] = 8'hFD;
          else             d[8*k +: 8] = ref_char(c);
        end
      end
    end
    return {d, f};
  endfunction

  // R1: self-synchronous scrambler x^58 + x^19 + 1, LSB first
  task automatic send(input logic [1:0] h, input logic [63:0] plain);
    logic [121:0] e;
    e[57:0] = sh;
    for (int i = 0; i < 64; i++) e[i+58] = plain[i] ^ e[i+19] ^ e[i];
    sh = e[121:64];
    @(negedge clk);
    in_valid = 1'b1;
    in_hdr   = h;
    in_body  = e[121:58];
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check(input bit ok, input string req, input logic [71:0] act,
                       input logic [71:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(MAX_CYC * 10);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", MAX_CYC, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [71:0] ex;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(out_valid == 1'b0, "R11 reset out_valid", {71'd0, out_valid}, 72'd0);
    // priming block: R2
    send(2'b10, mk_body(2'b10, 8'h17, 7'h16, 8'h00));
    check(out_valid == 1'b0, "R2 priming invalid", {71'd0, out_valid}, 72'd0);
    // table walk, R1 covered by every row through the scrambler
    for (int r = 0; r < NV; r++) begin
      send(VEC[r][29:28], mk_body(VEC[r][29:28], VEC[r][27:20], VEC[r][19:13], VEC[r][12:5]));
      ex = mk_exp(VEC[r][29:28], VEC[r][27:20], VEC[r][19:13], VEC[r][12:5], VEC[r][4]);
      check(out_valid && {out_data, out_ctrl} == ex,
            $sformatf("R%0d row %0d", VEC[r][3:0], r), {out_data, out_ctrl}, ex);
    end
    // R2: no input gives no output the next cycle
    @(negedge clk);
    check(out_valid == 1'b0, "R2 gap", {71'd0, out_valid}, 72'd0);
    // R11: reset inside a packet returns the checker to outside
    send(2'b10, mk_body(2'b10, 8'h71, 7'h00, 8'h33));
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(out_valid == 1'b0 && out_ctrl == 8'h00, "R11 reset outputs",
          {out_data, out_ctrl}, 72'd0);
    send(2'b10, mk_body(2'b10, 8'h17, 7'h16, 8'h00));
    check(out_valid == 1'b0, "R2 priming after reset", {71'd0, out_valid}, 72'd0);
    send(2'b01, mk_body(2'b01, 8'h00, 7'h00, 8'h44));
    ex = {{8{8'hFE}}, 8'hFF};
    check(out_valid && {out_data, out_ctrl} == ex, "R11 data after reset is outside",
          {out_data, out_ctrl}, ex);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule